// File: doc/BRIEF.md
# Partial Word Store Lane Generator

This block converts a partial-word store request into a single aligned word write on a big-endian memory port. A request carries a byte address, a 32-bit source word and a mode. In the head mode the low-order bytes of the source fill the word from the addressed byte up to the last byte of the word. In the tail mode the high-order bytes of the source fill the bytes that lie below the addressed byte.

Each accepted request yields one registered write one cycle later. The write has a word-aligned address, a byte-enable mask and lane-aligned data. Every store, the three-byte case included, leaves as one masked transaction, so no observer can see a partial result. In tail mode at a word-aligned address nothing is written. The block still raises a probe flag, so that the memory side checks write permission and marks the line dirty.

Top module: `psw_lane_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `outValid`, `outProbe`, `outByteEn`, `outAddr` and `outWdata` are all zero.
- R2: A request with `inValid` high yields exactly one cycle of `outValid` high, on the clock edge that follows the request. With `inValid` low, `outValid` is low one cycle later.
- R3: Big-endian lanes: the byte at word offset k uses data bits [31-8k:24-8k] and byte-enable bit 3-k. In head mode (`modeSel`=0) at offset o, `outByteEn` equals 4'b1111 shifted right by o, so offset 0 gives 1111 and offset 3 gives 0001.
- R4: In head mode the source bytes stay in their own lanes. At offset 3 only source bits [7:0] are written, and they go to the addressed byte.
- R5: In tail mode (`modeSel`=1) at offset o between 1 and 3, `outByteEn` enables the bytes below offset o, giving 1000, 1100 and 1110.
- R6: In tail mode the upper o source bytes are written to the o bytes just below the addressed byte. At offset 1 only source bits [31:24] are written, at word offset 0.
- R7: In tail mode at offset 0, `outProbe` is 1 and `outByteEn` is 0000. Memory contents are not changed.
- R8: `outAddr` equals the request address with its low two bits cleared.
- R9: `outWdata` bits in lanes that are not enabled are zero.
- R10: A three-byte store (head offset 1 or tail offset 3) is issued as one transaction with three enable bits set. It never uses two separate writes.
- R11: `outProbe` is raised only for a tail-mode request at offset 0. It is never raised for any other request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe |
| modeSel | input | 1 | 0 = head mode, 1 = tail mode |
| inAddr | input | 32 | Byte address of the request |
| inData | input | 32 | Source register word |
| outValid | output | 1 | One-cycle write strobe |
| outAddr | output | 32 | Word-aligned write address |
| outByteEn | output | 4 | Byte enables, bit 3 = lowest-addressed byte |
| outWdata | output | 32 | Lane-aligned write data |
| outProbe | output | 1 | Write-permission probe with no data |

## Verification
The bench runs every mode and every address offset with several data words. One word has distinct bytes, so a swapped lane shows up. Other words are all ones or alternating, which separate masking errors from data routing errors. Each write is applied to a byte-array memory that was pre-filled with a background pattern. A reference array is updated directly from the mode and offset rules. Comparing the two arrays catches stray bytes outside the intended range, including any write at all from the probe-only case. Idle cycles between requests show that `outValid` is a single pulse.

// File: rtl/psw_lane_pkg.sv
package psw_lane_pkg;

  typedef enum logic {
    MODE_HEAD = 1'b0,
    MODE_TAIL = 1'b1
  } store_mode_e;

  typedef struct packed {
    logic fire;
    logic probe;
  } lane_strobe_t;

endpackage

// File: rtl/psw_lane_ctrl.sv
module psw_lane_ctrl
  import psw_lane_pkg::*;
#(
  parameter int BYTES = 4,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic              inValid,
  input  logic              modeSel,
  input  logic [OFF_W-1:0]  offset,
  output lane_strobe_t      strobes,
  output logic [BYTES-1:0]  laneEn
);

  logic [BYTES-1:0] headMask;
  store_mode_e      mode;

  assign mode     = store_mode_e'(modeSel);
  assign headMask = {BYTES{1'b1}} >> offset;

  always_comb begin
    strobes.fire  = inValid;
    strobes.probe = 1'b0;
    laneEn        = '0;
    if (inValid) begin
      unique case (mode)
        MODE_HEAD: laneEn = headMask;
        MODE_TAIL: begin
          laneEn        = ~headMask;
          strobes.probe = (offset == '0);
        end
        default: laneEn = '0;
      endcase
    end
  end

endmodule

// File: rtl/psw_lane_dp.sv
module psw_lane_dp
  import psw_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BYTES  = 4,
  localparam int DATA_W = BYTES * 8,
  localparam int OFF_W  = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  lane_strobe_t      strobes,
  input  logic [BYTES-1:0]  laneEn,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic [BYTES-1:0]  outByteEn,
  output logic [DATA_W-1:0] outWdata,
  output logic              outProbe
);

  logic [DATA_W-1:0] maskedData;
  logic [ADDR_W-1:0] wordAddr;

  assign wordAddr = {inAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  for (genvar lane = 0; lane < BYTES; lane++) begin : g_lane
    assign maskedData[lane*8 +: 8] = laneEn[lane] ? inData[lane*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outAddr   <= '0;
      outByteEn <= '0;
      outWdata  <= '0;
      outProbe  <= 1'b0;
    end else if (strobes.fire) begin
      outValid  <= 1'b1;
      outAddr   <= wordAddr;
      outByteEn <= laneEn;
      outWdata  <= maskedData;
      outProbe  <= strobes.probe;
    end else begin
      outValid  <= 1'b0;
      outAddr   <= '0;
      outByteEn <= '0;
      outWdata  <= '0;
      outProbe  <= 1'b0;
    end
  end

endmodule

// File: rtl/psw_lane_gen.sv
module psw_lane_gen
  import psw_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BYTES  = 4,
  localparam int DATA_W = BYTES * 8,
  localparam int OFF_W  = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              modeSel,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic [BYTES-1:0]  outByteEn,
  output logic [DATA_W-1:0] outWdata,
  output logic              outProbe
);

  lane_strobe_t     strobes;
  logic [BYTES-1:0] laneEn;

  psw_lane_ctrl #(.BYTES(BYTES)) u_ctrl (
    .inValid (inValid),
    .modeSel (modeSel),
    .offset  (inAddr[OFF_W-1:0]),
    .strobes (strobes),
    .laneEn  (laneEn)
  );

  psw_lane_dp #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .laneEn    (laneEn),
    .inAddr    (inAddr),
    .inData    (inData),
    .outValid  (outValid),
    .outAddr   (outAddr),
    .outByteEn (outByteEn),
    .outWdata  (outWdata),
    .outProbe  (outProbe)
  );

endmodule

// File: rtl/psw_lane_gen_chk.sv
module psw_lane_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int BYTES  = 4,
  localparam int DATA_W = BYTES * 8,
  localparam int OFF_W  = $clog2(BYTES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              modeSel,
  input logic [ADDR_W-1:0] inAddr,
  input logic              outValid,
  input logic [ADDR_W-1:0] outAddr,
  input logic [BYTES-1:0]  outByteEn,
  input logic [DATA_W-1:0] outWdata,
  input logic              outProbe
);

  logic [DATA_W-1:0] enExpand;
  for (genvar lane = 0; lane < BYTES; lane++) begin : g_exp
    assign enExpand[lane*8 +: 8] = {8{outByteEn[lane]}};
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R2
  AST_PROBE_NO_EN: assert property (@(posedge clk) disable iff (!rstN)
    outProbe |-> (outByteEn == '0)); // R7
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outAddr[OFF_W-1:0] == '0)); // R8
  AST_DEAD_LANES_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (outWdata & ~enExpand) == '0); // R9
  AST_HEAD_LAST_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !modeSel) |=> outByteEn[0]); // R3
  AST_TAIL_NO_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeSel) |=> !outByteEn[0]); // R5
  AST_PROBE_ONLY_TAIL0: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !(modeSel && inAddr[OFF_W-1:0] == '0)) |=> !outProbe); // R11
  AST_WRITE_HAS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outProbe) |-> (outByteEn != '0)); // R10

endmodule

bind psw_lane_gen psw_lane_gen_chk #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .modeSel   (modeSel),
  .inAddr    (inAddr),
  .outValid  (outValid),
  .outAddr   (outAddr),
  .outByteEn (outByteEn),
  .outWdata  (outWdata),
  .outProbe  (outProbe)
);

// File: tb/psw_lane_gen_tb.sv
module psw_lane_gen_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        modeSel = 1'b0;
  logic [31:0] inAddr = '0;
  logic [31:0] inData = '0;
  logic        outValid;
  logic [31:0] outAddr;
  logic [3:0]  outByteEn;
  logic [31:0] outWdata;
  logic        outProbe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] dutMem [64];
  logic [7:0] refMem [64];

  always #4 clk = ~clk;

  psw_lane_gen u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .modeSel(modeSel),
    .inAddr(inAddr), .inData(inData), .outValid(outValid), .outAddr(outAddr),
    .outByteEn(outByteEn), .outWdata(outWdata), .outProbe(outProbe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doStore(input logic mode, input logic [5:0] addr, input logic [31:0] data);
    logic [1:0]  o;
    logic [3:0]  expEn;
    logic [31:0] expData;
    logic        expProbe;
    o        = addr[1:0];
    expEn    = mode ? (~(4'hF >> o) & 4'hF) : (4'hF >> o);
    expProbe = mode && (o == 2'd0);
    expData  = '0;
    for (int k = 0; k < 4; k++)
      if (expEn[3-k]) expData[31-8*k -: 8] = data[31-8*k -: 8];
    // reference memory from the mode rules
    if (!mode) begin
      for (int k = 0; k < 4; k++)
        if (k >= o) refMem[{addr[5:2], 2'b00} + k] = data[31-8*k -: 8];
    end else begin
      for (int k = 0; k < 4; k++)
        if (k < o) refMem[{addr[5:2], 2'b00} + k] = data[31-8*k -: 8];
    end
    @(negedge clk);
    inValid = 1'b1; modeSel = mode; inAddr = {26'h0, addr}; inData = data;
    @(negedge clk);
    inValid = 1'b0;
    chk("R2 valid", {31'd0, outValid}, 32'd1);
    chk(mode ? "R5 tail enables" : "R3 head enables", {28'd0, outByteEn}, {28'd0, expEn});
    chk(mode ? "R6 tail data" : "R4 head data", outWdata, expData);
    chk("R9 dead lanes", outWdata & ~{{8{expEn[3]}}, {8{expEn[2]}}, {8{expEn[1]}}, {8{expEn[0]}}}, 32'd0);
    chk("R8 address", outAddr, {26'h0, addr[5:2], 2'b00});
    chk(expProbe ? "R7 probe" : "R11 probe", {31'd0, outProbe}, {31'd0, expProbe});
    if ((!mode && o == 2'd1) || (mode && o == 2'd3))
      chk("R10 three bytes", $countones(outByteEn), 32'd3);
    if (outValid)
      for (int k = 0; k < 4; k++)
        if (outByteEn[3-k]) dutMem[outAddr[5:0] + k] = outWdata[31-8*k -: 8];
    @(negedge clk);
    chk("R2 single pulse", {31'd0, outValid}, 32'd0);
    for (int b = 0; b < 64; b++)
      if (dutMem[b] !== refMem[b]) chk("R7 memory", {24'd0, dutMem[b]}, {24'd0, refMem[b]});
    checks++;
  endtask

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h11223344; pats[1] = 32'hFFFFFFFF;
    pats[2] = 32'hA5C35A3C; pats[3] = 32'h8001FE7F;
    for (int b = 0; b < 64; b++) begin
      dutMem[b] = 8'(b * 7 + 3);
      refMem[b] = 8'(b * 7 + 3);
    end
    repeat (2) @(negedge clk);
    chk("R1 valid", {31'd0, outValid}, 32'd0);
    chk("R1 enables", {28'd0, outByteEn}, 32'd0);
    chk("R1 probe", {31'd0, outProbe}, 32'd0);
    chk("R1 data", outWdata, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", outAddr | {31'd0, outValid}, 32'd0);
    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 2; m++)
        for (int a = 0; a < 16; a++)
          doStore(m[0], 6'(a + 16 * (p % 3)), pats[p]);
    doStore(1'b0, 6'd7, 32'hDEADBE5A);
    chk("R4 lsb only", {24'd0, dutMem[7]}, 32'h5A);
    doStore(1'b1, 6'd9, 32'hC7000000);
    chk("R6 msb only", {24'd0, dutMem[8]}, 32'hC7);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule